// File: doc/BRIEF.md
# Flag-Selected Conditional Move Unit

This block executes one conditional-move operation at a time for a 64-bit integer pipeline. Each operation carries the decoded instruction fields: a 4-bit condition code, a 3-bit flag-set selector, an immediate-select bit, six reserved bits, an 11-bit signed immediate, the rs2 operand and the current rd value. It also carries two flag sets, one produced by 32-bit arithmetic and one by 64-bit arithmetic. The unit chooses a flag set, evaluates the condition and picks a register or an immediate source. It returns a write-enable for rd, the value to write and a flag that marks an illegal encoding.

Operations enter on a valid/ready input and leave on a valid/ready output through a single register stage. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented on `out_valid` from the following cycle. It stays there, unchanged, until a rising edge where `out_ready` is high. `in_ready` is high whenever the stage is empty or its content leaves on the same edge, so a consumer that keeps `out_ready` high gets one result per cycle. A consumer that holds `out_ready` low stalls the producer after one operation.

Top module: `cmov_unit`

## Requirements
- R1: Selector `{cc2,cc1,cc0}` = 3'b100 tests the 32-bit flag set `flags_w`, and 3'b110 tests the 64-bit flag set `flags_x`. Each flag set is packed as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.
- R2: Any other selector value gives `illegal` = 1 and `rd_we` = 0.
- R3: When `imm_sel` is 1, the source is `simm11` sign-extended to 64 bits.
- R4: When `imm_sel` is 0, the source is `rs2_val`. If `rsvd` is not zero while `imm_sel` is 0, `illegal` = 1 and `rd_we` = 0.
- R5: On a legal encoding, `rd_we` equals the result of the selected condition. `rd_data` is the source when `rd_we` is 1 and `rd_val` (rd unchanged) otherwise, including on illegal encodings.
- R6: The condition codes are: 0 never, 1 eq (Z), 2 le (Z or (N xor V)), 3 lt (N xor V), 4 leu (C or Z), 5 ltu (C), 6 neg (N), 7 vs (V). Codes 8 to 15 are the complements of codes 0 to 7 in the same order: always, ne, gt, ge, gtu, geu, pos, vc.
- R7: Code 0 (never) gives `rd_we` = 0 and code 8 (always) gives `rd_we` = 1 on a legal encoding, whatever the flag values.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `rd_we`, `rd_data` and `illegal` hold their values.
- R9: While `rst` is high and after it is released, `out_valid` is 0 until an operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit accepts the offered operation |
| cond | input | 4 | Condition code |
| cc_sel | input | 3 | Flag-set selector {cc2,cc1,cc0} |
| imm_sel | input | 1 | 1 selects the immediate source, 0 selects rs2 |
| rsvd | input | 6 | Reserved field, must be zero when imm_sel is 0 |
| simm11 | input | 11 | Signed immediate |
| flags_w | input | 4 | 32-bit flag set {N,Z,V,C} |
| flags_x | input | 4 | 64-bit flag set {N,Z,V,C} |
| rs2_val | input | 64 | rs2 operand value |
| rd_val | input | 64 | Current rd value |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the presented result |
| rd_we | output | 1 | Write rd |
| rd_data | output | 64 | Value for rd |
| illegal | output | 1 | Illegal encoding |

## Verification
Each result is due in the cycle after its operation is accepted and stays due until the consumer takes it. `in_ready` depends on the cycle's inputs without any register between them. The bench drives inputs at the falling edge and holds a behavioural model of the output stage that it updates with each predicted handshake. At every falling edge it compares `out_valid` and the held payload with the model, and a short delay after driving it compares `in_ready` with the model. Stretches of consumer stall exercise the hold rule. Directed phases sweep the selector values, both source kinds, the reserved-bit case and all sixteen condition codes against random flags.

// File: rtl/cmov_pkg.sv
package cmov_pkg;
  localparam int COND_W = 4;
  localparam int SEL_W  = 3;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef enum logic [COND_W-1:0] {
    C_NEVER = 4'd0,  C_EQ  = 4'd1,  C_LE  = 4'd2,  C_LT  = 4'd3,
    C_LEU   = 4'd4,  C_LTU = 4'd5,  C_NEG = 4'd6,  C_VS  = 4'd7,
    C_ALWAYS= 4'd8,  C_NE  = 4'd9,  C_GT  = 4'd10, C_GE  = 4'd11,
    C_GTU   = 4'd12, C_GEU = 4'd13, C_POS = 4'd14, C_VC  = 4'd15
  } cond_e;

  localparam logic [SEL_W-1:0] SEL_WORD  = 3'b100;
  localparam logic [SEL_W-1:0] SEL_XWORD = 3'b110;
endpackage

// File: rtl/cmov_cond_eval.sv
module cmov_cond_eval
  import cmov_pkg::*;
(
  input  flags_t              flags,
  input  logic [COND_W-1:0]   cond,
  output logic                take
);
  logic base;

  // Lower three bits pick a base test; the top bit complements it.
  always_comb begin
    unique case (cond[COND_W-2:0])
      3'd0: base = 1'b0;
      3'd1: base = flags.z;
      3'd2: base = flags.z | (flags.n ^ flags.v);
      3'd3: base = flags.n ^ flags.v;
      3'd4: base = flags.c | flags.z;
      3'd5: base = flags.c;
      3'd6: base = flags.n;
      default: base = flags.v;
    endcase
    take = base ^ cond[COND_W-1];
  end
endmodule

// File: rtl/cmov_decode.sv
module cmov_decode
  import cmov_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 11,
  parameter int RSVD_W = 6
) (
  input  logic [SEL_W-1:0]  cc_sel,
  input  logic              imm_sel,
  input  logic [RSVD_W-1:0] rsvd,
  input  logic [IMM_W-1:0]  simm,
  input  logic [DATA_W-1:0] rs2_val,
  output logic              use_x,
  output logic              illegal,
  output logic [DATA_W-1:0] src
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic sel_ok;
  logic rsvd_bad;

  always_comb begin
    sel_ok   = (cc_sel == SEL_WORD) || (cc_sel == SEL_XWORD);
    use_x    = (cc_sel == SEL_XWORD);
    rsvd_bad = !imm_sel && (rsvd != '0);
    illegal  = !sel_ok || rsvd_bad;
    src      = imm_sel ? {{EXT_W{simm[IMM_W-1]}}, simm} : rs2_val;
  end
endmodule

// File: rtl/cmov_out_reg.sv
module cmov_out_reg #(
  parameter int PAY_W = 66
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pay   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_pay <= in_pay;
    end
  end

  // R8: a stalled result holds still
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pay)));
endmodule

// File: rtl/cmov_unit.sv
module cmov_unit
  import cmov_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 11,
  parameter int RSVD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        cond,
  input  logic [2:0]        cc_sel,
  input  logic              imm_sel,
  input  logic [RSVD_W-1:0] rsvd,
  input  logic [IMM_W-1:0]  simm11,
  input  logic [3:0]        flags_w,
  input  logic [3:0]        flags_x,
  input  logic [DATA_W-1:0] rs2_val,
  input  logic [DATA_W-1:0] rd_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              rd_we,
  output logic [DATA_W-1:0] rd_data,
  output logic              illegal
);
  localparam int PAY_W = DATA_W + 2;

  logic              use_x;
  logic              dec_ill;
  logic [DATA_W-1:0] src;
  flags_t            flags_sel;
  logic              take;
  logic              we_c;
  logic [DATA_W-1:0] data_c;
  logic [PAY_W-1:0]  pay_c;
  logic [PAY_W-1:0]  pay_q;
  logic              fire;

  cmov_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W), .RSVD_W(RSVD_W)) u_dec (
    .cc_sel (cc_sel),
    .imm_sel(imm_sel),
    .rsvd   (rsvd),
    .simm   (simm11),
    .rs2_val(rs2_val),
    .use_x  (use_x),
    .illegal(dec_ill),
    .src    (src)
  );

  assign flags_sel = use_x ? flags_t'(flags_x) : flags_t'(flags_w);

  cmov_cond_eval u_cond (
    .flags(flags_sel),
    .cond (cond),
    .take (take)
  );

  always_comb begin
    we_c   = take && !dec_ill;
    data_c = we_c ? src : rd_val;
    pay_c  = {dec_ill, we_c, data_c};
  end

  cmov_out_reg #(.PAY_W(PAY_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_pay   (pay_c),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_pay  (pay_q)
  );

  assign illegal = pay_q[PAY_W-1];
  assign rd_we   = pay_q[PAY_W-2];
  assign rd_data = pay_q[DATA_W-1:0];

  assign fire = in_valid && in_ready;

  // R7: never does not write
  p_never_nowe_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && cond == C_NEVER) |=> !rd_we);

  // R7: always writes on a legal encoding
  p_always_we_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && cond == C_ALWAYS && (cc_sel == SEL_WORD || cc_sel == SEL_XWORD)
     && (imm_sel || rsvd == '0)) |=> rd_we);

  // R2: unknown selector is illegal and writes nothing
  p_badsel_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && cc_sel != SEL_WORD && cc_sel != SEL_XWORD) |=> (illegal && !rd_we));

  // R5: an illegal encoding passes rd through
  p_ill_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && dec_ill) |=> (rd_data == $past(rd_val)));
endmodule

// File: tb/sim_cmov_unit.sv
module sim_cmov_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, imm_sel, out_valid, out_ready, rd_we, illegal;
  logic [3:0]  cond, flags_w, flags_x;
  logic [2:0]  cc_sel;
  logic [5:0]  rsvd;
  logic [10:0] simm11;
  logic [63:0] rs2_val, rd_val, rd_data;

  always #10 clk = ~clk;

  cmov_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .cond(cond), .cc_sel(cc_sel), .imm_sel(imm_sel), .rsvd(rsvd),
    .simm11(simm11), .flags_w(flags_w), .flags_x(flags_x),
    .rs2_val(rs2_val), .rd_val(rd_val), .out_valid(out_valid),
    .out_ready(out_ready), .rd_we(rd_we), .rd_data(rd_data), .illegal(illegal)
  );

  int checks = 0;
  int errors = 0;

  logic        m_v, m_we, m_ill;
  logic [63:0] m_data;
  string       m_tag;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic cond_true(logic [3:0] c, logic [3:0] f);
    logic n, z, v, cy;
    {n, z, v, cy} = f;
    case (c)
      4'd0:  return 1'b0;
      4'd1:  return z;
      4'd2:  return z | (n ^ v);
      4'd3:  return n ^ v;
      4'd4:  return cy | z;
      4'd5:  return cy;
      4'd6:  return n;
      4'd7:  return v;
      4'd8:  return 1'b1;
      4'd9:  return !z;
      4'd10: return !(z | (n ^ v));
      4'd11: return !(n ^ v);
      4'd12: return !(cy | z);
      4'd13: return !cy;
      4'd14: return !n;
      default: return !v;
    endcase
  endfunction

  task automatic drive(int mode, int step);
    logic [2:0] s;
    in_valid  = 1'b1;
    out_ready = ($urandom % 4) != 0;
    cond      = 4'($urandom);
    cc_sel    = ($urandom % 2) ? 3'b110 : 3'b100;
    imm_sel   = 1'($urandom);
    rsvd      = 6'd0;
    simm11    = 11'($urandom);
    flags_w   = 4'($urandom);
    flags_x   = ~flags_w;
    rs2_val   = {$urandom, $urandom};
    rd_val    = {$urandom, $urandom};
    case (mode)
      0: begin in_valid = 1'b0; out_ready = 1'b1; end
      2: begin
           s = 3'($urandom);
           if (s == 3'b100 || s == 3'b110) s = 3'b000;
           cc_sel = s;
         end
      3: begin imm_sel = 1'b1; cond = 4'd8; end
      4: begin imm_sel = 1'b0; rsvd = ($urandom % 2) ? 6'd0 : 6'(1 << ($urandom % 6)); end
      5: begin cond = 4'(step); flags_x = 4'($urandom); end
      7: begin cond = ($urandom % 2) ? 4'd8 : 4'd0; imm_sel = 1'b1; end
      8: out_ready = ($urandom % 5) == 0;
      default: ;
    endcase
  endtask

  task automatic predict(string tag);
    logic        rdy, legal, ill, t;
    logic [3:0]  f;
    logic [63:0] sv;
    rdy = !m_v || out_ready;
    if (in_valid && rdy) begin
      legal = (cc_sel == 3'b100) || (cc_sel == 3'b110);
      f     = (cc_sel == 3'b110) ? flags_x : flags_w;
      ill   = !legal || (!imm_sel && rsvd != 6'd0);
      sv    = imm_sel ? {{53{simm11[10]}}, simm11} : rs2_val;
      t     = cond_true(cond, f);
      m_v   = 1'b1;
      m_ill = ill;
      m_we  = !ill && t;
      m_data = m_we ? sv : rd_val;
      m_tag = tag;
    end else if (m_v && out_ready) begin
      m_v = 1'b0;
    end
  endtask

  task automatic run(int mode, string tag, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R8", "out_valid", 64'(out_valid), 64'(m_v));
      if (m_v) begin
        check(m_tag, "rd_we", 64'(rd_we), 64'(m_we));
        check(m_tag, "rd_data", rd_data, m_data);
        check(m_tag, "illegal", 64'(illegal), 64'(m_ill));
      end
      drive(mode, k % 16);
      #1;
      check("R8", "in_ready", 64'(in_ready), 64'(!m_v || out_ready));
      predict(tag);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(0, 0);
    m_v = 1'b0; m_we = 1'b0; m_ill = 1'b0; m_data = '0; m_tag = "R9";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", "out_valid in reset", 64'(out_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "out_valid after reset", 64'(out_valid), 64'd0);
    check("R9", "in_ready after reset", 64'(in_ready), 64'd1);
    run(1, "R1", 200);
    run(2, "R2", 100);
    run(3, "R3", 100);
    run(4, "R4", 200);
    run(5, "R6", 640);
    run(6, "R5", 300);
    run(7, "R7", 200);
    run(8, "R8", 300);
    run(0, "R8", 8);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule